// File: doc/BRIEF.md
# Exception Priority Gate and Thread Control Registers

This unit sits next to a processor core. It holds two software-visible registers: a base-priority mask and a thread-control word. A 1-bit register port selects between them, and both can be read and written through it. The mask decides whether a pending exception may activate. An exception whose priority value is equal to or numerically above the programmed base is held off. A base of zero turns the mask off.

The control word holds three flags:
- Thread-mode privilege level.
- Active stack selection. This bit is forced to read as zero in handler mode, and software writes to it are dropped there. A return-from-exception strobe reloads it from hardware.
- Floating-point-context flag. The exception logic uses it to decide whether floating-point state needs saving. A context-set strobe raises it and an exception-entry strobe clears it.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The allow output is combinational from the stored mask and the incoming priority.

Top module: `prio_gate_unit`

## Requirements
- R1: After reset, both registers read zero, `stack_sel`, `thread_unpriv` and `fp_ctx_active` are 0, and `exc_allow` is 1 for any priority.
- R2: The mask register (`reg_sel`=0) stores only `reg_wdata[7:4]`; a read returns that field at bits 7:4 with bits 31:8 and 3:0 zero.
- R3: While the stored mask field is zero, `exc_allow` is 1 for every `exc_prio` value.
- R4: While the mask field B is nonzero, `exc_allow` is 1 exactly when `exc_prio[7:4]` < B (a smaller value is a more urgent exception), so equal or larger values are blocked.
- R5: Control bit 0 (`reg_sel`=1) is the thread privilege: 0 privileged, 1 unprivileged, driven on `thread_unpriv`; it is writable in both modes.
- R6: In thread mode (`handler_mode`=0), a write loads control bit 1 (0 main stack, 1 process stack), which reads back at bit 1 and drives `stack_sel`.
- R7: In handler mode, control bit 1 reads as 0, `stack_sel` is 0, and software writes to bit 1 are ignored; the stored value reappears once back in thread mode.
- R8: A cycle with `exc_ret`=1 loads control bit 1 from `exc_ret_spsel`, taking precedence over a software write in the same cycle.
- R9: Control bit 2 (1 = floating-point context active, on `fp_ctx_active`) is set by `fp_ctx_set` and cleared by `exc_entry`; entry wins over set, and both win over a software write. Control bits 31:3 read as zero.
- R10: A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 mask, 1 control |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| handler_mode | input | 1 | 1 while the core runs an exception handler |
| exc_ret | input | 1 | Return-from-exception strobe |
| exc_ret_spsel | input | 1 | Stack selection restored on return |
| fp_ctx_set | input | 1 | Marks the floating-point context active |
| exc_entry | input | 1 | Exception-entry strobe, clears the context flag |
| exc_prio | input | 8 | Priority value of the pending exception |
| exc_allow | output | 1 | 1 when the pending exception may activate |
| stack_sel | output | 1 | Active stack: 0 main, 1 process |
| thread_unpriv | output | 1 | Thread-mode privilege: 1 unprivileged |
| fp_ctx_active | output | 1 | Floating-point context active |

## Verification
The bench builds the unit with its defaults: a 32-bit register word, an 8-bit priority and a 4-bit kept mask field. With these values every mask level from 1 to 15 can be placed against priorities just below, at and above its boundary, including the extremes 0x00 and 0xFF. The reserved nibble below the field is loaded with ones to show it never takes part in the comparison. The handler/thread switch and the same-cycle collisions of return, entry, set and software write are driven directly.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;
  // register select values on the software port
  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_CTL  = 1'b1
  } reg_sel_e;

  // control word bit positions (software-visible)
  localparam int unsigned CTL_PRIV  = 0;
  localparam int unsigned CTL_SPSEL = 1;
  localparam int unsigned CTL_FPCTX = 2;
  localparam int unsigned CTL_BITS  = 3;
endpackage

// File: rtl/prio_gate_rst_sync.sv
module prio_gate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/prio_gate_maskreg.sv
module prio_gate_maskreg #(
  parameter int unsigned KEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KEEP_W-1:0] wr_fld,
  output logic [KEEP_W-1:0] fld_q
);
  logic [KEEP_W-1:0] fld_d;

  always_comb begin
    fld_d = fld_q;
    if (wr_en) fld_d = wr_fld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else        fld_q <= fld_d;
  end
endmodule

// File: rtl/prio_gate_cmp.sv
module prio_gate_cmp #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned KEEP_W = 4
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic [KEEP_W-1:0] base,
  output logic              allow
);
  localparam int unsigned LO = PRIO_W - KEEP_W;
  logic [KEEP_W-1:0] prio_hi;

  generate
    if (LO == 0) begin : g_full
      assign prio_hi = prio;
    end else begin : g_trunc
      logic [LO-1:0] unused_lo;
      assign unused_lo = prio[LO-1:0];
      assign prio_hi   = prio[PRIO_W-1:LO];
    end
  endgenerate

  always_comb begin
    if (base == '0) allow = 1'b1;
    else            allow = (prio_hi < base);
  end
endmodule

// File: rtl/prio_gate_ctlreg.sv
module prio_gate_ctlreg
  import prio_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTL_BITS-1:0] wr_bits,
  input  logic                handler_mode,
  input  logic                exc_ret,
  input  logic                exc_ret_spsel,
  input  logic                fp_ctx_set,
  input  logic                exc_entry,
  output logic                priv_q,
  output logic                spsel_q,
  output logic                fpctx_q
);
  logic priv_d, spsel_d, fpctx_d;

  always_comb begin
    priv_d = priv_q;
    if (wr_en) priv_d = wr_bits[CTL_PRIV];

    spsel_d = spsel_q;
    if (exc_ret)                    spsel_d = exc_ret_spsel;
    else if (wr_en && !handler_mode) spsel_d = wr_bits[CTL_SPSEL];

    fpctx_d = fpctx_q;
    if (exc_entry)       fpctx_d = 1'b0;
    else if (fp_ctx_set) fpctx_d = 1'b1;
    else if (wr_en)      fpctx_d = wr_bits[CTL_FPCTX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q  <= 1'b0;
      spsel_q <= 1'b0;
      fpctx_q <= 1'b0;
    end else begin
      priv_q  <= priv_d;
      spsel_q <= spsel_d;
      fpctx_q <= fpctx_d;
    end
  end
endmodule

// File: rtl/prio_gate_unit.sv
module prio_gate_unit
  import prio_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned KEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              handler_mode,
  input  logic              exc_ret,
  input  logic              exc_ret_spsel,
  input  logic              fp_ctx_set,
  input  logic              exc_entry,
  input  logic [PRIO_W-1:0] exc_prio,
  output logic              exc_allow,
  output logic              stack_sel,
  output logic              thread_unpriv,
  output logic              fp_ctx_active
);
  localparam int unsigned FLD_LO = PRIO_W - KEEP_W;

  logic              rst_n_int;
  logic              mask_we, ctl_we;
  logic [KEEP_W-1:0] base_fld;
  logic              priv_q, spsel_raw, fpctx_q;
  logic [DATA_W-1:0] mask_rd, ctl_rd;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[DATA_W-1:PRIO_W], reg_wdata[FLD_LO-1:CTL_BITS]};

  assign mask_we = reg_we && (reg_sel == SEL_MASK);
  assign ctl_we  = reg_we && (reg_sel == SEL_CTL);

  prio_gate_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  prio_gate_maskreg #(.KEEP_W(KEEP_W)) u_mask (
    .clk(clk), .rst_n(rst_n_int), .wr_en(mask_we),
    .wr_fld(reg_wdata[PRIO_W-1:FLD_LO]), .fld_q(base_fld)
  );

  prio_gate_cmp #(.PRIO_W(PRIO_W), .KEEP_W(KEEP_W)) u_cmp (
    .prio(exc_prio), .base(base_fld), .allow(exc_allow)
  );

  prio_gate_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n_int), .wr_en(ctl_we),
    .wr_bits(reg_wdata[CTL_BITS-1:0]), .handler_mode(handler_mode),
    .exc_ret(exc_ret), .exc_ret_spsel(exc_ret_spsel),
    .fp_ctx_set(fp_ctx_set), .exc_entry(exc_entry),
    .priv_q(priv_q), .spsel_q(spsel_raw), .fpctx_q(fpctx_q)
  );

  assign stack_sel     = spsel_raw && !handler_mode;
  assign thread_unpriv = priv_q;
  assign fp_ctx_active = fpctx_q;

  always_comb begin
    mask_rd = '0;
    mask_rd[PRIO_W-1:FLD_LO] = base_fld;
    ctl_rd = '0;
    ctl_rd[CTL_PRIV]  = priv_q;
    ctl_rd[CTL_SPSEL] = stack_sel;
    ctl_rd[CTL_FPCTX] = fpctx_q;
  end

  assign reg_rdata = (reg_sel == SEL_CTL) ? ctl_rd : mask_rd;
endmodule

// File: rtl/prio_gate_chk.sv
module prio_gate_chk #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned KEEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_n_int,
  input logic              reg_sel,
  input logic              reg_we,
  input logic              handler_mode,
  input logic              exc_ret,
  input logic              exc_ret_spsel,
  input logic              exc_entry,
  input logic [PRIO_W-1:0] exc_prio,
  input logic [KEEP_W-1:0] base_fld,
  input logic              spsel_raw,
  input logic              exc_allow,
  input logic              stack_sel,
  input logic              fp_ctx_active
);
  p_zero_base_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (base_fld == '0) |-> exc_allow);

  p_block_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((base_fld != '0) && (exc_prio[PRIO_W-1:PRIO_W-KEEP_W] >= base_fld)) |-> !exc_allow);

  p_handler_main_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    handler_mode |-> !stack_sel);

  p_ret_load_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    exc_ret |=> (spsel_raw == $past(exc_ret_spsel)));

  p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    exc_entry |=> !fp_ctx_active);

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(reg_we && !reg_sel) |=> $stable(base_fld));

  logic unused_rst;
  assign unused_rst = rst_n;
endmodule

bind prio_gate_unit prio_gate_chk #(.PRIO_W(PRIO_W), .KEEP_W(KEEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_n_int(rst_n_int), .reg_sel(reg_sel),
  .reg_we(reg_we), .handler_mode(handler_mode), .exc_ret(exc_ret),
  .exc_ret_spsel(exc_ret_spsel), .exc_entry(exc_entry), .exc_prio(exc_prio),
  .base_fld(base_fld), .spsel_raw(spsel_raw), .exc_allow(exc_allow),
  .stack_sel(stack_sel), .fp_ctx_active(fp_ctx_active)
);

// File: tb/prio_gate_unit_tb_top.sv
module prio_gate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        handler_mode = 1'b0, exc_ret = 1'b0, exc_ret_spsel = 1'b0;
  logic        fp_ctx_set = 1'b0, exc_entry = 1'b0;
  logic [7:0]  exc_prio = '0;
  logic        exc_allow, stack_sel, thread_unpriv, fp_ctx_active;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_gate_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .handler_mode(handler_mode),
    .exc_ret(exc_ret), .exc_ret_spsel(exc_ret_spsel), .fp_ctx_set(fp_ctx_set),
    .exc_entry(exc_entry), .exc_prio(exc_prio), .exc_allow(exc_allow),
    .stack_sel(stack_sel), .thread_unpriv(thread_unpriv),
    .fp_ctx_active(fp_ctx_active)
  );

  // {mask field, priority, expected allow}
  localparam logic [12:0] VEC [14] = '{
    {4'h0, 8'h00, 1'b1}, {4'h0, 8'hFF, 1'b1}, {4'h1, 8'h00, 1'b1},
    {4'h1, 8'h10, 1'b0}, {4'h1, 8'h0F, 1'b1}, {4'h8, 8'h7F, 1'b1},
    {4'h8, 8'h80, 1'b0}, {4'h8, 8'h8F, 1'b0}, {4'h8, 8'hFF, 1'b0},
    {4'hF, 8'hEF, 1'b1}, {4'hF, 8'hF0, 1'b0}, {4'h3, 8'h2C, 1'b1},
    {4'h3, 8'h30, 1'b0}, {4'h3, 8'h45, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] data);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic rd(input string req, input logic sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    rd("R1 mask", 1'b0, 32'h0);
    rd("R1 ctl", 1'b1, 32'h0);
    exc_prio = 8'hFF; #1;
    check("R1 allow", {31'd0, exc_allow}, 32'd1);
    check("R1 flags", {29'd0, stack_sel, thread_unpriv, fp_ctx_active}, 32'd0);

    // R2/R3/R4 vector walk; reserved bits of write data set to ones
    foreach (VEC[i]) begin
      wr(1'b0, {24'hA5C3F0, VEC[i][12:9], 4'hF});
      rd("R2 mask read", 1'b0, {24'd0, VEC[i][12:9], 4'h0});
      exc_prio = VEC[i][8:1];
      #1;
      check(VEC[i][12:9] == 4'h0 ? "R3 zero base allow" : "R4 masked allow",
            {31'd0, exc_allow}, {31'd0, VEC[i][0]});
    end

    // R5 privilege bit
    wr(1'b1, 32'h0000_0001);
    check("R5 unpriv", {31'd0, thread_unpriv}, 32'd1);
    rd("R5 read", 1'b1, 32'h1);
    // R10 control write kept mask (last vector base 3)
    rd("R10 mask kept", 1'b0, 32'h30);

    // R6 thread-mode stack select
    wr(1'b1, 32'h0000_0003);
    check("R6 stack_sel", {31'd0, stack_sel}, 32'd1);
    rd("R6 read", 1'b1, 32'h3);

    // R7 handler mode
    handler_mode = 1'b1; #1;
    rd("R7 handler read", 1'b1, 32'h1);
    check("R7 handler stack", {31'd0, stack_sel}, 32'd0);
    wr(1'b1, 32'h0000_0000);
    handler_mode = 1'b0; #1;
    rd("R7 write ignored", 1'b1, 32'h2);
    check("R5 priv writable in handler", {31'd0, thread_unpriv}, 32'd0);

    // R8 return beats same-cycle write
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'h2;
    exc_ret = 1'b1; exc_ret_spsel = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; exc_ret = 1'b0; #1;
    check("R8 ret wins", {31'd0, stack_sel}, 32'd0);
    @(negedge clk);
    exc_ret = 1'b1; exc_ret_spsel = 1'b1;
    @(negedge clk);
    exc_ret = 1'b0; #1;
    check("R8 ret load", {31'd0, stack_sel}, 32'd1);

    // R9 floating-point context
    @(negedge clk); fp_ctx_set = 1'b1;
    @(negedge clk); fp_ctx_set = 1'b0; #1;
    check("R9 set", {31'd0, fp_ctx_active}, 32'd1);
    @(negedge clk); fp_ctx_set = 1'b1; exc_entry = 1'b1;
    @(negedge clk); fp_ctx_set = 1'b0; exc_entry = 1'b0; #1;
    check("R9 entry wins", {31'd0, fp_ctx_active}, 32'd0);
    @(negedge clk); fp_ctx_set = 1'b1; reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'h2;
    @(negedge clk); fp_ctx_set = 1'b0; reg_we = 1'b0; #1;
    check("R9 set beats write", {31'd0, fp_ctx_active}, 32'd1);
    wr(1'b1, 32'hFFFF_FFF8);
    rd("R9 reserved zero", 1'b1, 32'h0);
    rd("R10 mask after ctl", 1'b0, 32'h30);
    step();

    finish_run();
  end
endmodule